// File: doc/BRIEF.md
# Quadrature Encoder Count-Pulse Converter

This block turns the two phase-shifted channels of an incremental encoder into count pulses for an up/down counter outside the block. Both channels are brought into the system clock domain and then cleaned by a digital filter. The filter accepts a new level only after that level has held for a set number of samples, so dither and short spikes are rejected. The filtered pair is decoded into steps and their direction. Each accepted step fires a fixed-width, active-low pulse whose length in clock cycles comes from an input word.

A mode input chooses between counting every valid edge of either channel and counting once per full quadrature cycle. In the second case only the rising edge of channel A counts. A format input chooses how the pulses leave the block. In split format, up pulses and down pulses each have their own line. In combined format, one line carries every pulse and a second line carries the direction. The direction level is set when a pulse starts and does not change until the pulse ends, so a counter that counts on the rising trailing edge always sees a settled direction.

Top module: `quad_count_clk`

## Requirements
- R1: While reset is low and after it is released, with the channels idle, `out_p` and `out_q` are both high and `step_err` is low.
- R2: A level change on one channel that lasts only FILT_LEN-1 clock cycles produces no output pulse.
- R3: A single valid edge on a channel, driven while the block is idle, makes the pulse line go low on the (FILT_LEN+3)-th rising clock edge after the change.
- R4: With `edge_mode`=1, every valid step of the {A,B} pair gives exactly one pulse, which is four per full cycle.
- R5: With `edge_mode`=0, only a rise of A counts, so there is one pulse per full cycle. Toggling B back and forth gives no pulse.
- R6: The step order {A,B} = 00→10→11→01→00 means A leads and counts up. The reverse order counts down. In once-per-cycle mode, a rise of A with B low counts up and a rise of A with B high counts down.
- R7: With `fmt_combined`=0, up pulses appear on `out_p` and down pulses on `out_q`, and the two lines are never low together.
- R8: With `fmt_combined`=1, every pulse appears on `out_p`. `out_q` is high for up and low for down, and it does not change while the pulse is low.
- R9: A pulse stays low for `pulse_len` clock cycles. A value of 0 gives one cycle.
- R10: A step in which A and B change together gives no pulse and raises `step_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_a | input | 1 | Encoder channel A (asynchronous) |
| chan_b | input | 1 | Encoder channel B (asynchronous) |
| edge_mode | input | 1 | 1: count every edge; 0: count once per cycle |
| fmt_combined | input | 1 | 1: pulse line plus direction level; 0: separate up/down lines |
| pulse_len | input | LEN_W | Pulse width in clock cycles (0 is treated as 1) |
| out_p | output | 1 | Up pulses (split) or all pulses (combined), active low |
| out_q | output | 1 | Down pulses (split) or direction, high meaning up (combined) |
| step_err | output | 1 | One-cycle flag for a step where both channels changed |

## Verification
A filter that accepts a level too early or too late shows up at the ports at once as glitches that get through or as a start latency different from FILT_LEN+3 cycles. A corrupted previous-state register shows up as wrong or missing counts on the very next step, or as a false `step_err`. Direction errors and one-shot errors become visible within one pulse width: a pulse lands on the wrong line, has the wrong length, or the direction level moves before the rising edge.

// File: rtl/quad_count_clk.sv
module quad_count_clk #(
  parameter int FILT_LEN = 4,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_a,
  input  logic             chan_b,
  input  logic             edge_mode,
  input  logic             fmt_combined,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             out_p,
  output logic             out_q,
  output logic             step_err
);

  localparam int CNT_W = $clog2(FILT_LEN + 1);

  // bit 1 = channel A, bit 0 = channel B
  logic [1:0]       s1, s2, flt, prev;
  logic [CNT_W-1:0] fcnt [2];
  logic [LEN_W-1:0] rem;
  logic             dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      flt  <= '0;
      prev <= '0;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      s1   <= {chan_a, chan_b};
      s2   <= s1;
      prev <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == CNT_W'(FILT_LEN - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  function automatic logic [1:0] pos_of(input logic [1:0] ab);
    case (ab)
      2'b00:   pos_of = 2'd0;
      2'b10:   pos_of = 2'd1;
      2'b11:   pos_of = 2'd2;
      default: pos_of = 2'd3;
    endcase
  endfunction

  wire moved  = flt != prev;
  wire both   = &(flt ^ prev);
  wire valid  = moved & ~both;
  wire fwd    = pos_of(flt) == pos_of(prev) + 2'd1;
  wire a_rise = flt[1] & ~prev[1] & ~both;
  wire ev     = edge_mode ? valid : a_rise;
  wire ev_up  = edge_mode ? fwd : ~flt[0];
  wire active = rem != '0;
  wire start  = ev & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      dir_q    <= 1'b1;
      step_err <= 1'b0;
    end else begin
      step_err <= moved & both;
      if (start) begin
        rem   <= (pulse_len == '0) ? LEN_W'(1) : pulse_len;
        dir_q <= ev_up;
      end else if (active) rem <= rem - 1'b1;
    end
  end

  assign out_p = fmt_combined ? ~active : ~(active & dir_q);
  assign out_q = fmt_combined ? dir_q   : ~(active & ~dir_q);

  assert_filter_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt != $past(flt)) |-> (flt == $past(s2)));

  assert_pulse_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem != LEN_W'(1)) |=> active);

  assert_dir_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rem != LEN_W'(1)) |=> $stable(dir_q));

  assert_split_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_combined |-> (out_p || out_q));

  assert_double_step_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && both && !active) |=> !active);

  assert_once_per_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !$past(edge_mode)) |-> ($past(flt[1]) && !$past(prev[1])));

endmodule

// File: tb/sim_quad_count_clk.sv
`timescale 1ns/1ps
module sim_quad_count_clk;
  localparam int FILT_LEN = 4;
  localparam int LEN_W    = 8;
  localparam int GAP      = 24;

  logic clk = 1'b0, rst_n = 1'b0, chan_a = 1'b0, chan_b = 1'b0;
  logic edge_mode = 1'b1, fmt_combined = 1'b0;
  logic [LEN_W-1:0] pulse_len = 8'd3;
  logic out_p, out_q, step_err;

  always #10 clk = ~clk;

  quad_count_clk #(.FILT_LEN(FILT_LEN), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_a(chan_a), .chan_b(chan_b),
    .edge_mode(edge_mode), .fmt_combined(fmt_combined), .pulse_len(pulse_len),
    .out_p(out_p), .out_q(out_q), .step_err(step_err));

  int n_chk = 0, n_bad = 0;
  int nup = 0, ndn = 0, nerr = 0, viol = 0, w = 0, lastw = 0;
  logic prev_low = 1'b0, dir_at = 1'b1;
  int pos = 0;

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    logic low_now;
    low_now = !out_p || (!fmt_combined && !out_q);
    if (step_err) nerr++;
    if (!out_p && !out_q && !fmt_combined) viol++;
    if (low_now && !prev_low) begin
      w = 1;
      dir_at = out_q;
      if (fmt_combined ? out_q : !out_p) nup++; else ndn++;
    end else if (low_now) begin
      w++;
      if (fmt_combined && out_q != dir_at) viol++;
    end else if (prev_low) lastw = w;
    prev_low = low_now;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ab_at(input int p);
    case (p)
      0: ab_at = 2'b00;
      1: ab_at = 2'b10;
      2: ab_at = 2'b11;
      default: ab_at = 2'b01;
    endcase
  endfunction

  task automatic step(input bit up);
    pos = up ? (pos + 1) % 4 : (pos + 3) % 4;
    {chan_a, chan_b} = ab_at(pos);
    repeat (GAP) @(negedge clk);
  endtask

  // {edge_mode, fmt, len[7:0], up, nsteps[7:0], exp_up[7:0], exp_dn[7:0], exp_w[7:0]}
  localparam int NV = 9;
  localparam logic [42:0] TAB [NV] = '{
    {1'b1, 1'b0, 8'd3,  1'b1, 8'd8,  8'd8,  8'd0,  8'd3},   // R4 R6 R7
    {1'b1, 1'b0, 8'd3,  1'b0, 8'd8,  8'd0,  8'd8,  8'd3},   // R4 R6 R7
    {1'b0, 1'b0, 8'd4,  1'b1, 8'd8,  8'd2,  8'd0,  8'd4},   // R5 R6
    {1'b0, 1'b0, 8'd4,  1'b0, 8'd8,  8'd0,  8'd2,  8'd4},   // R5 R6
    {1'b1, 1'b1, 8'd5,  1'b1, 8'd4,  8'd4,  8'd0,  8'd5},   // R8
    {1'b1, 1'b1, 8'd5,  1'b0, 8'd12, 8'd0,  8'd12, 8'd5},   // R8
    {1'b0, 1'b1, 8'd2,  1'b0, 8'd4,  8'd0,  8'd1,  8'd2},   // R5 R8
    {1'b1, 1'b0, 8'd0,  1'b1, 8'd4,  8'd4,  8'd0,  8'd1},   // R9 zero length
    {1'b1, 1'b1, 8'd16, 1'b1, 8'd4,  8'd4,  8'd0,  8'd16}   // R9 long
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int u0c, d0c, e0c, lat;
    repeat (3) @(negedge clk);
    chk("R1 reset out_p", out_p, 1);
    chk("R1 reset out_q", out_q, 1);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 idle pulses", nup + ndn, 0);
    chk("R1 idle err", nerr, 0);
    chk("R1 idle out_p", out_p, 1);

    foreach (TAB[i]) begin
      logic [42:0] v;
      v = TAB[i];
      edge_mode = v[42]; fmt_combined = v[41]; pulse_len = v[40:33];
      repeat (4) @(negedge clk);
      u0c = nup; d0c = ndn;
      for (int k = 0; k < int'(v[31:24]); k++) step(v[32]);
      repeat (40) @(negedge clk);
      chk($sformatf("R4/R5/R6 up count vec %0d", i), nup - u0c, int'(v[23:16]));
      chk($sformatf("R4/R5/R6 down count vec %0d", i), ndn - d0c, int'(v[15:8]));
      chk($sformatf("R9 width vec %0d", i), lastw, int'(v[7:0]));
    end
    chk("R7 R8 line and direction violations", viol, 0);

    // R5: B dither in once-per-cycle mode gives nothing
    edge_mode = 1'b0; fmt_combined = 1'b0; pulse_len = 8'd3;
    u0c = nup; d0c = ndn;
    for (int k = 0; k < 8; k++) step(k % 2 == 1);
    repeat (30) @(negedge clk);
    chk("R5 B dither pulses", (nup - u0c) + (ndn - d0c), 0);

    // R4: same dither in every-edge mode: 4 down, 4 up
    edge_mode = 1'b1;
    u0c = nup; d0c = ndn;
    for (int k = 0; k < 8; k++) step(k % 2 == 1);
    repeat (30) @(negedge clk);
    chk("R4 dither up", nup - u0c, 4);
    chk("R4 dither down", ndn - d0c, 4);

    // R2: glitch of FILT_LEN-1 cycles on A
    u0c = nup + ndn;
    chan_a = 1'b1;
    repeat (FILT_LEN - 1) @(negedge clk);
    chan_a = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 glitch rejected", nup + ndn - u0c, 0);

    // R3: latency from edge to pulse start
    lat = 0;
    chan_a = 1'b1; pos = 1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (!out_p && lat == 0) lat = k;
    end
    chk("R3 start latency", lat, FILT_LEN + 3);
    repeat (20) @(negedge clk);
    chan_a = 1'b0; pos = 0;
    repeat (30) @(negedge clk);

    // R10: both channels change together
    u0c = nup + ndn; e0c = nerr;
    {chan_a, chan_b} = 2'b11;
    repeat (GAP) @(negedge clk);
    {chan_a, chan_b} = 2'b00;
    repeat (GAP) @(negedge clk);
    chk("R10 no pulse on double change", nup + ndn - u0c, 0);
    chk("R10 error flags", nerr - e0c, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule